// File: doc/BRIEF.md
# LVDS 7:1 Pixel Serializer

This block turns a stream of parallel pixels into the bit-serial form used by a 7:1 flat-panel link. It runs in the bit-clock domain, seven bit clocks per pixel period, and on every bit clock it emits one bit on each of four data lanes plus one bit of a lane clock. Each pixel holds 8-bit red, green and blue components and three control bits: horizontal sync, vertical sync and data enable.

A two-bit layout selector picks how colour and control bits are spread over the seven slots of a pixel period. One layout is an 18-bit, three-lane layout. The other two are 24-bit, four-lane layouts that do not agree with each other. The selector is taken together with each pixel, so a layout can only change on a pixel boundary.

Pixels enter through a valid/ready handshake. Before the first transfer the block is idle and holds `pix_ready` high. After that `pix_ready` is high for one bit clock in every seven, in the last slot of the pixel period being sent. The source may hold a pixel with `pix_valid` for as long as it likes; the block never stalls its own output. If no pixel is offered in the ready cycle, the block sends a blank pixel in its place.

Top module: `lvds_pixel_serializer`

## Requirements
- R1: After a synchronous active-high reset, and until the first accepted pixel, `lane_data` and `lane_clk` are 0 and `pix_ready` is 1.
- R2: A pixel transfers on a clock edge where `pix_valid` and `pix_ready` are both 1. Its slot 0 appears on the lanes in the following cycle, and slots 1 to 6 follow in the next six cycles. From the first transfer on, `pix_ready` is 1 only during slot 6.
- R3: Once running, `lane_clk` follows slots 0 to 6 as 1,1,0,0,0,1,1 in every pixel period.
- R4: Selector code 0 is the 18-bit layout and uses colour bits 5..0. For slots 0 to 6: lane 0 is G0,R5,R4,R3,R2,R1,R0; lane 1 is B1,B0,G5,G4,G3,G2,G1; lane 2 is DE,VS,HS,B5,B4,B3,B2; lane 3 is 0 in every slot.
- R5: Selector code 1 sends lanes 0 to 2 exactly as in R4, using bits 5..0. For slots 0 to 6, lane 3 is 0,B7,B6,G7,G6,R7,R6.
- R6: Selector code 2 uses bits 7..2 on lanes 0 to 2. For slots 0 to 6: lane 0 is G2,R7,R6,R5,R4,R3,R2; lane 1 is B3,B2,G7,G6,G5,G4,G3; lane 2 is DE,VS,HS,B7,B6,B5,B4; lane 3 is 0,B1,B0,G1,G0,R1,R0.
- R7: Data enable goes in lane 2 slot 0, vertical sync in lane 2 slot 1 and horizontal sync in lane 2 slot 2. Lane 3 slot 0 is always 0.
- R8: Selector code 3 is sent exactly as code 0.
- R9: If `pix_valid` is 0 in a ready cycle after the first transfer, the next period carries a blank pixel. A blank pixel has all colour bits 0 and DE 0, and it repeats the previous period's syncs and layout.
- R10: Changes on the pixel inputs, on `map_sel` and on `pix_valid` while `pix_ready` is 0 have no effect on the pixel being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Bit clock, seven cycles per pixel period |
| rst | input | 1 | Synchronous active-high reset |
| pix_valid | input | 1 | Source offers a pixel |
| pix_ready | output | 1 | Block accepts a pixel on this edge |
| pix_red | input | 8 | Red component |
| pix_grn | input | 8 | Green component |
| pix_blu | input | 8 | Blue component |
| pix_hs | input | 1 | Horizontal sync |
| pix_vs | input | 1 | Vertical sync |
| pix_de | input | 1 | Data enable |
| map_sel | input | 2 | Layout select, captured with the pixel (0/3: 18-bit, 1 and 2: 24-bit) |
| lane_data | output | 4 | Serial data, one bit per lane per bit clock |
| lane_clk | output | 1 | Lane clock pattern |

## Verification
The assertions assume that reset is held for at least one edge before traffic. They also assume that `pix_valid`, `map_sel` and the control inputs carry known values in every cycle where `pix_ready` is 1, since those values are sampled there. The stimulus drives every input from time zero, holds reset for several cycles, and sends random junk on all pixel inputs, the selector and `pix_valid` while `pix_ready` is low. It recovers pixels by finding slot 0 from the lane clock and decoding the lanes, so a change in layout, slot order or blank insertion shows up as a mismatch on the decoded colour or control bits.

// File: rtl/lvds_map_pkg.sv
package lvds_map_pkg;

  localparam int COLOR_W  = 8;
  localparam int FIELD_W  = 6;
  localparam int EXTRA_W  = COLOR_W - FIELD_W;
  localparam int SLOT_CNT = 7;
  localparam int LANE_CNT = 4;
  localparam int SLOT_W   = $clog2(SLOT_CNT);

  // bit s is the lane clock level in slot s
  localparam logic [SLOT_CNT-1:0] LCLK_PATTERN = 7'b1100011;

  typedef enum logic [1:0] {
    MAP_18      = 2'd0,
    MAP_24_LOW  = 2'd1,
    MAP_24_HIGH = 2'd2
  } map_e;

  typedef struct packed {
    logic [COLOR_W-1:0] red;
    logic [COLOR_W-1:0] grn;
    logic [COLOR_W-1:0] blu;
    logic               hs;
    logic               vs;
    logic               de;
  } pixel_t;

  function automatic map_e decode_map(input logic [1:0] code);
    case (code)
      2'd1:    return MAP_24_LOW;
      2'd2:    return MAP_24_HIGH;
      default: return MAP_18;
    endcase
  endfunction

endpackage

// File: rtl/lvds_slot_ctr.sv
module lvds_slot_ctr #(
  parameter int SLOTS = 7,
  localparam int SW = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  output logic          run_o,
  output logic [SW-1:0] slot_o,
  output logic          ready_o
);

  localparam logic [SW-1:0] LAST = SW'(SLOTS - 1);

  logic          run_q;
  logic [SW-1:0] slot_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      slot_q <= '0;
    end else if (!run_q) begin
      if (take) begin
        run_q  <= 1'b1;
        slot_q <= '0;
      end
    end else if (slot_q == LAST) begin
      slot_q <= '0;
    end else begin
      slot_q <= slot_q + 1'b1;
    end
  end

  assign run_o   = run_q;
  assign slot_o  = slot_q;
  assign ready_o = !run_q || (slot_q == LAST);

endmodule

// File: rtl/lvds_pix_capture.sv
module lvds_pix_capture
  import lvds_map_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       take,
  input  logic       refill,
  input  pixel_t     pix_i,
  input  logic [1:0] map_i,
  output pixel_t     hold_o,
  output map_e       map_o
);

  pixel_t hold_q;
  map_e   map_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
      map_q  <= MAP_18;
    end else if (take) begin
      hold_q <= pix_i;
      map_q  <= decode_map(map_i);
    end else if (refill) begin
      hold_q.red <= '0;
      hold_q.grn <= '0;
      hold_q.blu <= '0;
      hold_q.de  <= 1'b0;
    end
  end

  assign hold_o = hold_q;
  assign map_o  = map_q;

endmodule

// File: rtl/lvds_lane_map.sv
module lvds_lane_map
  import lvds_map_pkg::*;
(
  input  pixel_t              pix,
  input  map_e                map,
  input  logic [SLOT_W-1:0]   slot,
  input  logic                run,
  output logic [LANE_CNT-1:0] lane_o,
  output logic                lclk_o
);

  logic [FIELD_W-1:0]  xr, xg, xb;
  logic [EXTRA_W-1:0]  er, eg, eb;
  logic [SLOT_CNT-1:0] word [LANE_CNT];

  always_comb begin
    if (map == MAP_24_HIGH) begin
      xr = pix.red[COLOR_W-1:EXTRA_W];
      xg = pix.grn[COLOR_W-1:EXTRA_W];
      xb = pix.blu[COLOR_W-1:EXTRA_W];
      er = pix.red[EXTRA_W-1:0];
      eg = pix.grn[EXTRA_W-1:0];
      eb = pix.blu[EXTRA_W-1:0];
    end else begin
      xr = pix.red[FIELD_W-1:0];
      xg = pix.grn[FIELD_W-1:0];
      xb = pix.blu[FIELD_W-1:0];
      er = pix.red[COLOR_W-1:FIELD_W];
      eg = pix.grn[COLOR_W-1:FIELD_W];
      eb = pix.blu[COLOR_W-1:FIELD_W];
    end
  end

  // word bit s is the lane bit sent in slot s
  always_comb begin
    word[0] = {xr[0], xr[1], xr[2], xr[3], xr[4], xr[5], xg[0]};
    word[1] = {xg[1], xg[2], xg[3], xg[4], xg[5], xb[0], xb[1]};
    word[2] = {xb[2], xb[3], xb[4], xb[5], pix.hs, pix.vs, pix.de};
    if (map == MAP_18) begin
      word[3] = '0;
    end else begin
      word[3] = {er[0], er[1], eg[0], eg[1], eb[0], eb[1], 1'b0};
    end
  end

  for (genvar l = 0; l < LANE_CNT; l++) begin : g_lane
    assign lane_o[l] = run & word[l][slot];
  end

  assign lclk_o = run & LCLK_PATTERN[slot];

endmodule

// File: rtl/lvds_pixel_serializer.sv
module lvds_pixel_serializer
  import lvds_map_pkg::*;
(
  input  logic                clk_bit,
  input  logic                rst,
  input  logic                pix_valid,
  output logic                pix_ready,
  input  logic [COLOR_W-1:0]  pix_red,
  input  logic [COLOR_W-1:0]  pix_grn,
  input  logic [COLOR_W-1:0]  pix_blu,
  input  logic                pix_hs,
  input  logic                pix_vs,
  input  logic                pix_de,
  input  logic [1:0]          map_sel,
  output logic [LANE_CNT-1:0] lane_data,
  output logic                lane_clk
);

  logic              run_q;
  logic [SLOT_W-1:0] slot_q;
  logic              take;
  logic              refill;
  pixel_t            pix_in;
  pixel_t            hold_q;
  map_e              map_q;

  assign take   = pix_valid & pix_ready;
  assign refill = run_q & pix_ready & ~pix_valid;
  assign pix_in = '{red: pix_red, grn: pix_grn, blu: pix_blu,
                    hs: pix_hs, vs: pix_vs, de: pix_de};

  lvds_slot_ctr #(.SLOTS(SLOT_CNT)) u_ctr (
    .clk     (clk_bit),
    .rst     (rst),
    .take    (take),
    .run_o   (run_q),
    .slot_o  (slot_q),
    .ready_o (pix_ready)
  );

  lvds_pix_capture u_cap (
    .clk    (clk_bit),
    .rst    (rst),
    .take   (take),
    .refill (refill),
    .pix_i  (pix_in),
    .map_i  (map_sel),
    .hold_o (hold_q),
    .map_o  (map_q)
  );

  lvds_lane_map u_map (
    .pix    (hold_q),
    .map    (map_q),
    .slot   (slot_q),
    .run    (run_q),
    .lane_o (lane_data),
    .lclk_o (lane_clk)
  );

endmodule

// File: rtl/lvds_pixel_serializer_chk.sv
module lvds_pixel_serializer_chk
  import lvds_map_pkg::*;
(
  input logic                clk_bit,
  input logic                rst,
  input logic                pix_valid,
  input logic                pix_ready,
  input logic                pix_de,
  input logic [1:0]          map_sel,
  input logic [LANE_CNT-1:0] lane_data,
  input logic                lane_clk,
  input logic                run_q,
  input pixel_t              hold_q
);

  p_idle_quiet_r1: assert property (@(posedge clk_bit) disable iff (rst)
    !run_q |-> (lane_data == '0 && !lane_clk && pix_ready));

  p_ready_once_r2: assert property (@(posedge clk_bit) disable iff (rst)
    (run_q && pix_ready) |=> !pix_ready);

  p_lclk_shape_r3: assert property (@(posedge clk_bit) disable iff (rst)
    (pix_valid && pix_ready) |=> lane_clk ##1 lane_clk ##1 !lane_clk ##1 !lane_clk
                                 ##1 !lane_clk ##1 lane_clk ##1 lane_clk);

  p_lane3_quiet_r4: assert property (@(posedge clk_bit) disable iff (rst)
    (pix_valid && pix_ready && (map_sel == 2'd0 || map_sel == 2'd3))
      |=> !lane_data[3] ##1 !lane_data[3] ##1 !lane_data[3] ##1 !lane_data[3]
          ##1 !lane_data[3] ##1 !lane_data[3] ##1 !lane_data[3]);

  p_ctl_slot0_r7: assert property (@(posedge clk_bit) disable iff (rst)
    (pix_valid && pix_ready) |=> (!lane_data[3] && lane_data[2] == $past(pix_de)));

  p_blank_de_r9: assert property (@(posedge clk_bit) disable iff (rst)
    (run_q && pix_ready && !pix_valid) |=> (!lane_data[2] && lane_clk));

  p_hold_stable_r10: assert property (@(posedge clk_bit) disable iff (rst)
    (run_q && !pix_ready) |=> $stable(hold_q));

endmodule

bind lvds_pixel_serializer lvds_pixel_serializer_chk u_chk (
  .clk_bit   (clk_bit),
  .rst       (rst),
  .pix_valid (pix_valid),
  .pix_ready (pix_ready),
  .pix_de    (pix_de),
  .map_sel   (map_sel),
  .lane_data (lane_data),
  .lane_clk  (lane_clk),
  .run_q     (run_q),
  .hold_q    (hold_q)
);

// File: tb/test_lvds_pixel_serializer.sv
module test_lvds_pixel_serializer;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 4096;
  localparam int N_RAND     = 400;
  localparam logic [6:0] PAT = 7'b1100011;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pix_valid = 1'b0;
  logic       pix_ready;
  logic [7:0] pix_red = '0, pix_grn = '0, pix_blu = '0;
  logic       pix_hs = 1'b0, pix_vs = 1'b0, pix_de = 1'b0;
  logic [1:0] map_sel = '0;
  logic [3:0] lane_data;
  logic       lane_clk;

  always #(CLK_PERIOD / 2) clk = ~clk;

  lvds_pixel_serializer i_lvds_pixel_serializer (
    .clk_bit   (clk),
    .rst       (rst),
    .pix_valid (pix_valid),
    .pix_ready (pix_ready),
    .pix_red   (pix_red),
    .pix_grn   (pix_grn),
    .pix_blu   (pix_blu),
    .pix_hs    (pix_hs),
    .pix_vs    (pix_vs),
    .pix_de    (pix_de),
    .map_sel   (map_sel),
    .lane_data (lane_data),
    .lane_clk  (lane_clk)
  );

  int checks = 0;
  int errors = 0;

  logic [7:0] exp_r [DEPTH];
  logic [7:0] exp_g [DEPTH];
  logic [7:0] exp_b [DEPTH];
  logic [2:0] exp_ctl [DEPTH];   // {hs, vs, de}
  logic [1:0] exp_mode [DEPTH];
  string      exp_tag [DEPTH];
  int  wr = 0;
  int  rd = 0;
  bit  have_first = 0;
  logic       last_hs = 0, last_vs = 0;
  logic [1:0] last_mode = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  task automatic record(input logic [7:0] r, g, b, input logic hs, vs, de,
                        input logic [1:0] mode, input string tag);
    if (wr < DEPTH) begin
      exp_r[wr] = r; exp_g[wr] = g; exp_b[wr] = b;
      exp_ctl[wr] = {hs, vs, de}; exp_mode[wr] = mode; exp_tag[wr] = tag;
      wr++;
    end
    last_hs = hs; last_vs = vs; last_mode = mode;
  endtask

  function automatic string mode_tag(input logic [1:0] m);
    case (m)
      2'd0: return "R4";
      2'd1: return "R5";
      2'd2: return "R6";
      default: return "R8";
    endcase
  endfunction

  task automatic drive_junk();
    pix_valid = 1'($urandom);
    pix_red = 8'($urandom); pix_grn = 8'($urandom); pix_blu = 8'($urandom);
    pix_hs = 1'($urandom); pix_vs = 1'($urandom); pix_de = 1'($urandom);
    map_sel = 2'($urandom);
  endtask

  // wait for a ready cycle (junk while not ready, R10), then offer a pixel or a gap
  task automatic offer(input bit v, input logic [7:0] r, g, b,
                       input logic hs, vs, de, input logic [1:0] mode);
    bit done = 0;
    while (!done) begin
      @(negedge clk);
      if (pix_ready) begin
        pix_valid = v;
        pix_red = r; pix_grn = g; pix_blu = b;
        pix_hs = hs; pix_vs = vs; pix_de = de; map_sel = mode;
        @(posedge clk);
        if (v) begin
          record(r, g, b, hs, vs, de, mode, {mode_tag(mode), "/R10"});
          have_first = 1;
        end else if (have_first) begin
          record(8'h00, 8'h00, 8'h00, last_hs, last_vs, 1'b0, last_mode, "R9");
        end
        done = 1;
      end else begin
        drive_junk();
        @(posedge clk);
      end
    end
  endtask

  // monitor: recover slot 0 from the lane clock and decode the lanes
  bit         mon_on = 0;
  int         ph = 0;
  logic [6:0] w [4];

  always @(negedge clk) begin
    if (!rst) begin
      if (!mon_on) begin
        if (lane_clk) begin
          mon_on = 1;
          ph = 0;
        end else begin
          check(lane_data == 4'h0 && pix_ready, "R1", "idle lanes/ready",
                {lane_data, pix_ready}, 5'h01);
        end
      end
      if (mon_on) begin
        check(lane_clk == PAT[ph], "R3", $sformatf("lane clock slot %0d", ph),
              lane_clk, PAT[ph]);
        check(pix_ready == (ph == 6), "R2", $sformatf("ready in slot %0d", ph),
              pix_ready, ph == 6);
        for (int l = 0; l < 4; l++) w[l][ph] = lane_data[l];
        if (ph == 6) decode();
        ph = (ph == 6) ? 0 : ph + 1;
      end
    end
  end

  task automatic decode();
    logic [5:0] xr, xg, xb;
    logic [1:0] er, eg, eb;
    logic [7:0] dr, dg, db, er_, eg_, eb_;
    logic [1:0] m;
    if (rd >= wr) return;
    xr = {w[0][1], w[0][2], w[0][3], w[0][4], w[0][5], w[0][6]};
    xg = {w[1][2], w[1][3], w[1][4], w[1][5], w[1][6], w[0][0]};
    xb = {w[2][3], w[2][4], w[2][5], w[2][6], w[1][0], w[1][1]};
    eb = {w[3][1], w[3][2]};
    eg = {w[3][3], w[3][4]};
    er = {w[3][5], w[3][6]};
    m  = exp_mode[rd];
    er_ = exp_r[rd]; eg_ = exp_g[rd]; eb_ = exp_b[rd];
    if (m == 2'd1) begin
      dr = {er, xr}; dg = {eg, xg}; db = {eb, xb};
    end else if (m == 2'd2) begin
      dr = {xr, er}; dg = {xg, eg}; db = {xb, eb};
    end else begin
      dr = {2'b00, xr}; dg = {2'b00, xg}; db = {2'b00, xb};
      er_ = er_ & 8'h3F; eg_ = eg_ & 8'h3F; eb_ = eb_ & 8'h3F;
      check(w[3] == 7'h00, exp_tag[rd], "lane 3 idle in 18-bit layout", w[3], 0);
    end
    check({dr, dg, db} == {er_, eg_, eb_}, exp_tag[rd],
          $sformatf("colours of pixel %0d", rd), {dr, dg, db}, {er_, eg_, eb_});
    check({w[2][2], w[2][1], w[2][0]} == exp_ctl[rd] && !w[3][0], "R7",
          $sformatf("controls of pixel %0d", rd),
          {w[3][0], w[2][2], w[2][1], w[2][0]}, {1'b0, exp_ctl[rd]});
    rd++;
  endtask

  bit timed_out = 0;

  initial begin
    void'($urandom(32'h0007_1a5e));
    fork
      begin
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        repeat (6) @(negedge clk);           // R1 idle window with valid low
        // directed corners
        offer(1, 8'hFF, 8'hFF, 8'hFF, 1, 1, 1, 2'd0);
        offer(1, 8'hFF, 8'hFF, 8'hFF, 1, 1, 1, 2'd1);
        offer(1, 8'hFF, 8'hFF, 8'hFF, 1, 1, 1, 2'd2);
        offer(1, 8'hA5, 8'h5A, 8'h3C, 0, 1, 1, 2'd3);
        offer(1, 8'hC3, 8'h81, 8'h42, 1, 0, 1, 2'd1);
        offer(0, 8'hFF, 8'hFF, 8'hFF, 1, 1, 1, 2'd2);   // gap: blank, R9
        offer(1, 8'h12, 8'h34, 8'h56, 1, 0, 1, 2'd2);
        offer(1, 8'h01, 8'h80, 8'h7E, 0, 0, 0, 2'd2);
        offer(0, 8'h00, 8'h00, 8'h00, 0, 0, 0, 2'd0);
        offer(0, 8'h00, 8'h00, 8'h00, 0, 0, 0, 2'd1);
        for (int i = 0; i < N_RAND; i++) begin
          offer(($urandom % 10) != 0, 8'($urandom), 8'($urandom), 8'($urandom),
                1'($urandom), 1'($urandom), 1'($urandom), 2'($urandom));
        end
        @(negedge clk) pix_valid = 1'b0;
        repeat (30) @(negedge clk);
        check(rd == wr, "R2", "all accepted pixels delivered", rd, wr);
      end
      begin
        repeat (150000) @(posedge clk);
        timed_out = 1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      errors++;
      checks++;
      $display("FAIL R2 watchdog: actual %0d expected %0d pixels", rd, wr);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule